// File: doc/BRIEF.md
# Selectable-Source Programmable Clock Divider

This cell produces one derived clock from a set of candidate sources. A first selector picks either a primary reference or one of up to eight PLL outputs. The chosen source then goes through one of three paths: straight through, a programmable divider driven by a 3-bit code, or a fixed divide-by-3 path that overrides the other two. A final gate enables or silences the result. All control inputs are static configuration levels.

The cell is modelled inside a single fast clock domain. Each candidate source arrives as a one-cycle clock-enable pulse train on that fast clock. The cell produces two outputs. The first is a divided strobe that pulses once per output period. The second is a level output clock with a defined duty cycle. A ratio change is held back until the current output period ends, and the gate only moves at that same boundary. As a result, neither a reconfiguration nor an enable change can create a truncated pulse. The cell also reports the index of the parent currently selected.

Top module: `clkdiv_cell`

## Requirements
- R1: With `pll_switch`=0 the divider counts pulses of `ref_ce`. With `pll_switch`=1 it counts pulses of bit `pll_select` of `pll_ce`. Every `out_ce` pulse follows a pulse of the selected source.
- R2: `parent_idx` is 0 while `pll_switch`=0, and `pll_select`+1 while `pll_switch`=1.
- R3: With `div3_switch`=0 and `div_switch`=1, one `out_ce` pulse occurs per N source pulses. N is set by `div_select` as follows: code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 6, 4 gives 8, 5 gives 12, and codes 6 and 7 give 1.
- R4: With `div3_switch`=1 the ratio is 3, whatever `div_switch` and `div_select` hold.
- R5: With `div3_switch`=0 and `div_switch`=0 the ratio is 1.
- R6: For an even ratio N, `out_clk` is high for N/2 source periods of each output period and low for the remaining N/2. For ratio 3 it is high for 1 source period and low for 2. For ratio 1, `out_clk` equals `out_ce`.
- R7: Once the gate is closed (`enable`=0), `out_ce` stays 0 and `out_clk` stays low with no transitions.
- R8: A change of ratio takes effect only at the next output period boundary, so the period in progress completes at its old length.
- R9: `enable` is sampled only at an output period boundary, where `out_clk` is low. After the gate reopens, the first high phase has its full length.
- R10: A synchronous active-low reset `rst_n` drives `out_ce` and `out_clk` low by the first clock edge at which it is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast modelling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_ce | input | 1 | Primary reference pulse train |
| pll_ce | input | NUM_PLL | PLL output pulse trains |
| pll_switch | input | 1 | 0 selects the reference, 1 selects a PLL |
| pll_select | input | 3 | PLL index |
| div_switch | input | 1 | 1 enables the programmable divider |
| div_select | input | 3 | Programmable divider code |
| div3_switch | input | 1 | 1 forces the divide-by-3 path |
| enable | input | 1 | Output gate enable |
| parent_idx | output | 4 | Logical index of the selected parent |
| out_ce | output | 1 | One pulse per output period |
| out_clk | output | 1 | Duty-cycled output clock |

## Verification
The bench sweeps every combination of source switch, divide-by-3 override, divider bypass and divider code. For each one it measures the spacing of `out_ce` in pulses of the selected source, and the high time of `out_clk`. Several faults show up as a wrong spacing: a table entry off by one, a bypass that leaks the programmed code, an override that loses to the divider, or a mux that counts the wrong PLL. A ratio change made partway through a long period must leave that period at its old length. A design that loads the new ratio at once would produce a short period. The bench also closes the gate and watches for any stray strobe or edge. After reopening, it checks that the first high phase is complete, which a design that gates asynchronously would truncate.

// File: rtl/clkdiv_cell.sv
module clkdiv_cell #(
  parameter int NUM_PLL = 8,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_ce,
  input  logic [NUM_PLL-1:0] pll_ce,
  input  logic               pll_switch,
  input  logic [2:0]         pll_select,
  input  logic               div_switch,
  input  logic [2:0]         div_select,
  input  logic               div3_switch,
  input  logic               enable,
  output logic [3:0]         parent_idx,
  output logic               out_ce,
  output logic               out_clk
);

  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  function automatic logic [RATIO_W-1:0] code_ratio(input logic [2:0] code);
    case (code)
      3'd1:    code_ratio = RATIO_W'(2);
      3'd2:    code_ratio = RATIO_W'(4);
      3'd3:    code_ratio = RATIO_W'(6);
      3'd4:    code_ratio = RATIO_W'(8);
      3'd5:    code_ratio = RATIO_W'(12);
      default: code_ratio = ONE;
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] r);
    high_len = (r == RATIO_W'(3)) ? ONE : (r >> 1);
  endfunction

  logic               pll_sel_ok, pll_pick, src_ce;
  logic [RATIO_W-1:0] tgt_ratio, act_ratio, cnt, cnt_inc;
  logic               last, gate_q, lvl_q, ce_q;

  assign pll_sel_ok = 32'(pll_select) < NUM_PLL;
  assign pll_pick   = pll_sel_ok ? pll_ce[pll_select] : 1'b0;
  assign src_ce     = pll_switch ? pll_pick : ref_ce;
  assign parent_idx = pll_switch ? ({1'b0, pll_select} + 4'd1) : 4'd0;

  assign tgt_ratio = div3_switch ? RATIO_W'(3) :
                     div_switch  ? code_ratio(div_select) : ONE;

  assign cnt_inc = cnt + ONE;
  assign last    = (cnt_inc == act_ratio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_ratio <= ONE;
      gate_q    <= 1'b0;
      lvl_q     <= 1'b0;
      ce_q      <= 1'b0;
    end else begin
      ce_q <= 1'b0;
      if (src_ce) begin
        if (last) begin
          cnt       <= '0;
          act_ratio <= tgt_ratio;
          gate_q    <= enable;
          ce_q      <= enable;
          lvl_q     <= enable && (high_len(tgt_ratio) != '0) && (tgt_ratio != ONE);
        end else begin
          cnt   <= cnt_inc;
          lvl_q <= gate_q && (cnt_inc < high_len(act_ratio));
        end
      end
    end
  end

  assign out_ce  = ce_q;
  assign out_clk = (act_ratio == ONE) ? ce_q : lvl_q;

  // R10
  rst_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_ce && !out_clk));

  // R1
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ce |-> $past(src_ce));

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_ratio) |-> $past(src_ce && last));

  // R9
  gate_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !$past(lvl_q));

  // R7
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> (!out_ce && !out_clk));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act_ratio);

endmodule

// File: tb/tb_clkdiv_cell.sv
`timescale 1ns/1ps
module tb_clkdiv_cell;
  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ce = 1'b0;
  logic [NP-1:0] pll_ce = '0;
  logic pll_switch = 1'b0;
  logic [2:0] pll_select = 3'd0;
  logic div_switch = 1'b0;
  logic [2:0] div_select = 3'd0;
  logic div3_switch = 1'b0;
  logic enable = 1'b0;
  logic [3:0] parent_idx;
  logic out_ce, out_clk;

  int checks = 0, errors = 0;
  bit done = 0;

  int srcs = 0, last_src = 0, int_len = 0, hi_acc = 0, hi_last = 0;
  int strobes = 0, toggles = 0;
  logic prev_clk = 1'b0;
  int ref_ctr = 0;
  int pll_ctr [NP];

  always #2 clk = ~clk;

  clkdiv_cell #(.NUM_PLL(NP)) dut (
    .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .pll_ce(pll_ce),
    .pll_switch(pll_switch), .pll_select(pll_select),
    .div_switch(div_switch), .div_select(div_select),
    .div3_switch(div3_switch), .enable(enable),
    .parent_idx(parent_idx), .out_ce(out_ce), .out_clk(out_clk));

  initial for (int i = 0; i < NP; i++) pll_ctr[i] = 0;

  always @(negedge clk) begin
    if (out_ce) begin
      int_len  = srcs - last_src;
      last_src = srcs;
      hi_last  = hi_acc;
      hi_acc   = 0;
      strobes++;
    end
    hi_acc += int'(out_clk);
    if (out_clk != prev_clk) toggles++;
    prev_clk = out_clk;
    ref_ce  = (ref_ctr == 0);
    ref_ctr = (ref_ctr + 1) % 3;
    for (int i = 0; i < NP; i++) begin
      pll_ce[i]  = (pll_ctr[i] == 0);
      pll_ctr[i] = (pll_ctr[i] + 1) % (2 + i);
    end
    srcs += int'(pll_switch ? pll_ce[pll_select] : ref_ce);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input bit d3, input bit ds, input int sel);
    int t [8] = '{1, 2, 4, 6, 8, 12, 1, 1};
    if (d3) return 3;
    if (!ds) return 1;
    return t[sel];
  endfunction

  function automatic int src_period();
    return pll_switch ? 2 + int'(pll_select) : 3;
  endfunction

  task automatic wait_strobe();
    int s = strobes;
    while (strobes == s) @(posedge clk);
  endtask

  task automatic set_cfg(input bit ps, input int psel, input bit d3, input bit ds, input int dsel);
    @(posedge clk); #1;
    pll_switch = ps; pll_select = 3'(psel);
    div3_switch = d3; div_switch = ds; div_select = 3'(dsel);
  endtask

  task automatic test_reset();
    repeat (5) @(negedge clk);
    check(out_ce == 1'b0, "R10 out_ce in reset", int'(out_ce), 0);
    check(out_clk == 1'b0, "R10 out_clk in reset", int'(out_clk), 0);
    @(posedge clk); #1; rst_n = 1'b1; enable = 1'b1;
  endtask

  task automatic test_parent();
    for (int ps = 0; ps < 2; ps++)
      for (int s = 0; s < 8; s++) begin
        set_cfg(ps[0], s, 1'b0, 1'b0, 0);
        @(negedge clk);
        check(int'(parent_idx) == (ps ? s + 1 : 0), "R2 parent_idx", int'(parent_idx), ps ? s + 1 : 0);
      end
  endtask

  task automatic test_sweep();
    for (int ps = 0; ps < 2; ps++)
      for (int d3 = 0; d3 < 2; d3++)
        for (int ds = 0; ds < 2; ds++)
          for (int sel = 0; sel < 8; sel++) begin
            int n = exp_ratio(d3[0], ds[0], sel);
            int hi = (n == 3) ? 1 : n / 2;
            set_cfg(ps[0], sel, d3[0], ds[0], sel);
            wait_strobe(); wait_strobe(); wait_strobe();
            for (int k = 0; k < 2; k++) begin
              wait_strobe();
              // R1 R3 R4 R5: spacing in pulses of the selected source
              check(int_len == n, d3 ? "R4 ratio" : (ds ? "R3 ratio" : "R5 ratio"), int_len, n);
              if (n != 1)
                check(hi_last == hi * src_period(), "R6 high time", hi_last, hi * src_period());
            end
          end
  endtask

  task automatic test_ratio1_clk();
    set_cfg(1'b0, 0, 1'b0, 1'b0, 0);
    wait_strobe(); wait_strobe(); wait_strobe();
    @(negedge clk); @(negedge clk);
    // R6: ratio 1 output clock copies the strobe
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(out_clk == out_ce, "R6 ratio1 copy", int'(out_clk), int'(out_ce));
    end
  endtask

  task automatic test_resync();
    set_cfg(1'b0, 0, 1'b0, 1'b1, 5);
    wait_strobe(); wait_strobe(); wait_strobe();
    repeat (9) @(posedge clk);
    #1; div_select = 3'd1;
    wait_strobe();
    check(int_len == 12, "R8 old period kept", int_len, 12);
    wait_strobe();
    check(int_len == 2, "R8 new period", int_len, 2);
  endtask

  task automatic test_gate();
    int s0, t0;
    set_cfg(1'b1, 2, 1'b0, 1'b1, 3);
    wait_strobe(); wait_strobe();
    @(posedge clk); #1; enable = 1'b0;
    repeat (60) @(posedge clk);
    s0 = strobes; t0 = toggles;
    repeat (300) @(negedge clk);
    check(strobes == s0, "R7 no strobes", strobes - s0, 0);
    check(toggles == t0, "R7 no edges", toggles - t0, 0);
    check(out_clk == 1'b0, "R7 clk low", int'(out_clk), 0);
    @(posedge clk); #1; enable = 1'b1;
    wait_strobe(); wait_strobe();
    check(hi_last == 3 * 4, "R9 full first high", hi_last, 12);
  endtask

  task automatic test_midreset();
    set_cfg(1'b0, 0, 1'b0, 1'b1, 1);
    wait_strobe();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(out_clk == 1'b0, "R10 out_clk after reset", int'(out_clk), 0);
    check(out_ce == 1'b0, "R10 out_ce after reset", int'(out_ce), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    wait_strobe(); wait_strobe();
    check(int_len == 2, "R10 resumes", int_len, 2);
  endtask

  initial begin
    test_reset();
    test_parent();
    test_sweep();
    test_ratio1_clk();
    test_resync();
    test_gate();
    test_midreset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule